// File: doc/BRIEF.md
# Four-Port Crossbar Switch with Output Conflict Resolution

The block connects each of its input ports to the output port that the input asks for. Every input carries a valid flag, a destination index and a data word. In each cycle a central control stage looks at all requests together and builds a matrix of crosspoint enables, with one on/off bit for every pair of input and output. When the requests form a permutation, every input reaches its output in the same cycle. When several inputs name the same output, the lowest-numbered valid input gets that output and the others are refused for that cycle. The block does not buffer or retry a refused input. That is left to the logic that surrounds it.

The switch registers its results. Output valid flags, output data and the per-input grant report all appear one clock after the requests are sampled, and they appear together. An output that no input won drives valid low and a zero data word. The port count and the data width are parameters. The defaults are four ports and 32-bit words.

Top module: `xbar_switch`

## Requirements
- R1: While reset is low, all output valid flags, output data words and grant bits are zero, and they clear as soon as reset falls.
- R2: When the valid requests form a permutation, every such input is granted and its data word appears on the output named by its destination index.
- R3: When several valid inputs name the same output, only the lowest-numbered of them is granted and connected, and the others get a grant of zero for that cycle.
- R4: An input whose valid flag is low is never granted, and its destination index does not block a higher-numbered valid input.
- R5: An output that no input won drives valid low and a data word of zero.
- R6: Grants, output valid flags and output data that result from one set of requests all appear on the first rising clock edge after those requests are sampled, and they do not appear before it.
- R7: Each output carries the data of at most one input, so a contested output shows the winner's word unchanged and never a merge of several words.
- R8: In every cycle, the number of grant bits set equals the number of output valid flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Assertion takes effect at once, release is synchronized |
| in_valid | input | NUM_PORTS | Request flag, one bit per input (bit i belongs to input i) |
| in_dest | input | NUM_PORTS x IDX_W | Destination output index for each input (field i occupies bits [IDX_W*i +: IDX_W]) |
| in_data | input | NUM_PORTS x DATA_W | Data word for each input (field i belongs to input i) |
| out_valid | output | NUM_PORTS | Bit o is high when output o carries a connected input |
| out_data | output | NUM_PORTS x DATA_W | Data word on each output. Zero when that output is not valid |
| in_grant | output | NUM_PORTS | Bit i is high when input i was connected in the cycle whose results are shown |

## Verification
Every result of the switch is due exactly one rising edge after the requests are sampled: grants, output valid flags and output data. The bench drives each stimulus on a falling edge. Just after it drives, it confirms that the outputs still show the previous result. It then compares the new result at the following falling edge, half a period after the sampling edge. Reset is different. Its assertion clears the outputs without waiting for a clock, so the bench checks those values a fraction of a nanosecond after reset falls. After release it waits for the two synchronizer stages plus one capture edge before it expects a result.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int XBAR_PORTS  = 4;
  localparam int XBAR_DATA_W = 32;

  // Index width for a port count, never below one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/xbar_req_decode.sv
module xbar_req_decode #(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_PORTS-1:0]                 req_valid,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]      req_dest,
  output logic [NUM_PORTS-1:0][NUM_PORTS-1:0]  req_mat    // [output][input]
);

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
      assign req_mat[o][i] = req_valid[i] && (req_dest[i] == IDX_W'(o));
    end
  end

endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req_mat,   // [output][input]
  output logic [NUM_PORTS-1:0][NUM_PORTS-1:0] xp_en,     // [output][input]
  output logic [NUM_PORTS-1:0]                grant
);

  // Fixed priority per output column: the lowest input index wins
  always_comb begin
    xp_en = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      logic taken;
      taken = 1'b0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        xp_en[o][i] = req_mat[o][i] & ~taken;
        taken       = taken | req_mat[o][i];
      end
    end
  end

  always_comb begin
    grant = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      grant = grant | xp_en[o];
    end
  end

endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32
) (
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] xp_en,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]    src_data,
  output logic [NUM_PORTS-1:0]                mux_valid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    mux_data
);

  // AND-OR selection; a column holds at most one enable
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      mux_valid[o] = |xp_en[o];
      mux_data[o]  = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        mux_data[o] = mux_data[o] | (src_data[i] & {DATA_W{xp_en[o][i]}});
      end
    end
  end

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int NUM_PORTS = XBAR_PORTS,
  parameter int DATA_W    = XBAR_DATA_W
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic [NUM_PORTS-1:0]                             in_valid,
  input  logic [NUM_PORTS-1:0][idx_width(NUM_PORTS)-1:0]   in_dest,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]                 in_data,
  output logic [NUM_PORTS-1:0]                             out_valid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]                 out_data,
  output logic [NUM_PORTS-1:0]                             in_grant
);

  localparam int IDX_W = idx_width(NUM_PORTS);

  logic                                rst_sync_n;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req_mat;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] xp_en;
  logic [NUM_PORTS-1:0]                grant_comb;
  logic [NUM_PORTS-1:0]                mux_valid;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    mux_data;

  logic [NUM_PORTS-1:0]                valid_d, valid_q;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    data_d,  data_q;
  logic [NUM_PORTS-1:0]                grant_d, grant_q;

  xbar_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  xbar_req_decode #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_decode (
    .req_valid (in_valid),
    .req_dest  (in_dest),
    .req_mat   (req_mat)
  );

  xbar_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arbiter (
    .req_mat (req_mat),
    .xp_en   (xp_en),
    .grant   (grant_comb)
  );

  xbar_out_mux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_mux (
    .xp_en     (xp_en),
    .src_data  (in_data),
    .mux_valid (mux_valid),
    .mux_data  (mux_data)
  );

  // Next-state
  always_comb begin
    valid_d = mux_valid;
    data_d  = mux_data;
    grant_d = grant_comb;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
      data_q  <= '0;
      grant_q <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      grant_q <= grant_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign in_grant  = grant_q;

endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk
  import xbar_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32
) (
  input logic                                             clk,
  input logic                                             rst_n,
  input logic [NUM_PORTS-1:0]                             in_valid,
  input logic [NUM_PORTS-1:0][idx_width(NUM_PORTS)-1:0]   in_dest,
  input logic [NUM_PORTS-1:0][DATA_W-1:0]                 in_data,
  input logic [NUM_PORTS-1:0][NUM_PORTS-1:0]              xp_en,
  input logic [NUM_PORTS-1:0]                             out_valid,
  input logic [NUM_PORTS-1:0][DATA_W-1:0]                 out_data,
  input logic [NUM_PORTS-1:0]                             in_grant
);

  localparam int IDX_W = idx_width(NUM_PORTS);

  logic [NUM_PORTS-1:0]              prev_valid;
  logic [NUM_PORTS-1:0][IDX_W-1:0]   prev_dest;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  prev_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= '0;
      prev_dest  <= '0;
      prev_data  <= '0;
    end else begin
      prev_valid <= in_valid;
      prev_dest  <= in_dest;
      prev_data  <= in_data;
    end
  end

  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      assert_reset_clear_R1: assert (out_valid == '0 && in_grant == '0);
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    // R2, R6: a grant shows the input's word on its chosen output in the same cycle
    assert_grant_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_grant[i] |-> (out_valid[prev_dest[i]] && out_data[prev_dest[i]] == prev_data[i]));

    assert_idle_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !prev_valid[i] |-> !in_grant[i]);

    for (genvar j = 0; j < i; j++) begin : g_lower
      assert_low_index_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_grant[i] |-> !(prev_valid[j] && prev_dest[j] == prev_dest[i]));
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    assert_single_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xp_en[o]));

    assert_idle_output_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[o] |-> (out_data[o] == '0));
  end

  assert_grant_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_grant) == $countones(out_valid));

endmodule

bind xbar_switch xbar_switch_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DATA_W    (DATA_W)
) u_xbar_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_dest   (in_dest),
  .in_data   (in_data),
  .xp_en     (xp_en),
  .out_valid (out_valid),
  .out_data  (out_data),
  .in_grant  (in_grant)
);

// File: tb/test_xbar_switch.sv
`timescale 1ns/1ps
module test_xbar_switch;

  localparam int N  = 4;
  localparam int W  = 32;
  localparam int IW = 2;
  localparam int NV = 10;

  // Vector layout: valid[27:24] dest[23:16] exp_grant[15:12] exp_outvalid[11:8] exp_src[7:0]
  // dest and src pack one 2-bit index per port, port 0 in the lowest bits.
  localparam logic [27:0] VECS [NV] = '{
    {4'b1111, 8'hE4, 4'b1111, 4'b1111, 8'hE4},  // identity permutation (R2)
    {4'b1111, 8'h1B, 4'b1111, 4'b1111, 8'h1B},  // reversal permutation (R2)
    {4'b1111, 8'hD2, 4'b1111, 4'b1111, 8'hC9},  // mixed permutation (R2)
    {4'b1111, 8'h5B, 4'b0111, 4'b1110, 8'h18},  // inputs 2,3 both to output 1 (R3)
    {4'b1111, 8'hAA, 4'b0001, 4'b0100, 8'h00},  // all to output 2 (R3, R5)
    {4'b1110, 8'hAA, 4'b0010, 4'b0100, 8'h10},  // input 0 idle, rest to output 2 (R4)
    {4'b0000, 8'hE4, 4'b0000, 4'b0000, 8'h00},  // nothing valid (R4, R5)
    {4'b1111, 8'hF5, 4'b0101, 4'b1010, 8'h80},  // two contested outputs (R3, R7)
    {4'b1000, 8'h00, 4'b1000, 4'b0001, 8'h03},  // only input 3 valid, all name output 0 (R4)
    {4'b1110, 8'h2A, 4'b1010, 4'b0101, 8'h13}   // idle input 0 shares output 2 (R4, R3)
  };

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [N-1:0]              in_valid;
  logic [N-1:0][IW-1:0]      in_dest;
  logic [N-1:0][W-1:0]       in_data;
  logic [N-1:0]              out_valid;
  logic [N-1:0][W-1:0]       out_data;
  logic [N-1:0]              in_grant;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xbar_switch #(.NUM_PORTS(N), .DATA_W(W)) i_xbar_switch (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dest   (in_dest),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .in_grant  (in_grant)
  );

  function automatic logic [W-1:0] mk_data(input int v, input int i);
    return 32'hC0DE0000 | W'(v << 8) | W'(i + 1);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int v);
    in_valid = VECS[v][27:24];
    in_dest  = VECS[v][23:16];
    for (int i = 0; i < N; i++) in_data[i] = mk_data(v, i);
  endtask

  task automatic check_vec(input int v);
    logic [N-1:0] eg;
    logic [N-1:0] ev;
    logic [7:0]   es;
    eg = VECS[v][15:12];
    ev = VECS[v][11:8];
    es = VECS[v][7:0];
    chk($sformatf("R2 R3 R4 grant vec%0d", v), W'(in_grant), W'(eg));
    chk($sformatf("R5 out_valid vec%0d", v), W'(out_valid), W'(ev));
    chk($sformatf("R8 grant count vec%0d", v), W'($countones(in_grant)), W'($countones(out_valid)));
    for (int o = 0; o < N; o++) begin
      logic [W-1:0] ed;
      ed = ev[o] ? mk_data(v, int'(es[2*o +: 2])) : '0;
      chk($sformatf("R2 R7 R5 out_data[%0d] vec%0d", o, v), out_data[o], ed);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = '0;
    in_dest  = '0;
    in_data  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", W'(out_valid), '0);
    chk("R1 reset grant", W'(in_grant), '0);
    chk("R1 reset out_data[0]", out_data[0], '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", W'(out_valid), '0);

    for (int v = 0; v < NV; v++) begin
      drive(v);
      #0.5;
      if (v > 0) begin
        // R6: nothing new before the sampling edge
        chk($sformatf("R6 early grant vec%0d", v), W'(in_grant), W'(VECS[v-1][15:12]));
        chk($sformatf("R6 early out_valid vec%0d", v), W'(out_valid), W'(VECS[v-1][11:8]));
      end
      @(posedge clk);
      @(negedge clk);
      check_vec(v);
    end

    // Reset in mid-traffic clears at once and recovers afterwards
    drive(0);
    @(posedge clk);
    @(negedge clk);
    check_vec(0);
    rst_n = 1'b0;
    #0.5;
    chk("R1 async clear out_valid", W'(out_valid), '0);
    chk("R1 async clear grant", W'(in_grant), '0);
    chk("R1 async clear out_data[3]", out_data[3], '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 held during sync release", W'(out_valid), '0);
    repeat (3) @(negedge clk);
    check_vec(0);

    summary();
    $finish;
  end

endmodule